// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out the effective address of a memory operand from the contents of one general register and a chosen addressing mode. For the two auto-modifying modes it also produces the new register value, with a one-cycle write-back enable that the register file uses to store it. The operand size sets the step of the modification: 1 for a byte, 2 for a word, 4 for a longword and 8 for a quadword.

In post-increment mode the access uses the old register value and the register then moves up by the step. In pre-decrement mode the register moves down by the step first, and the lowered value is both the address and the new register contents. The block does not translate addresses. It reports whether the address is virtual and must be translated. Where several virtual spaces are in use, it also passes on the address-space identifier that goes with the access. A start strobe samples all inputs, and every result appears on registered outputs one clock later.

Top module: `opnd_ea_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first start, every output is zero.
- R2: Mode 2'b00 (register direct) sets `direct_o`=1 and `ea_o`=register value. It leaves `wb_en_o`=0, `xlat_req_o`=0 and `asid_o`=0.
- R3: Mode 2'b01 (register indirect) gives `ea_o`=register value, `direct_o`=0, `wb_en_o`=0 and `wb_data_o`=register value (unchanged).
- R4: Mode 2'b10 (post-increment) gives `ea_o`=register value and `wb_data_o`=register value + step, with `wb_en_o`=1.
- R5: Mode 2'b11 (pre-decrement) gives `ea_o`=`wb_data_o`=register value − step, with `wb_en_o`=1.
- R6: The step follows `size_i`: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R7: Both the increment and the decrement wrap modulo 2^32. For example, 32'hFFFFFFFF post-incremented by a byte gives 0, and 0 pre-decremented by a quadword gives 32'hFFFFFFF8.
- R8: `wb_en_o` is high only in the cycle after a start in mode 2'b10 or 2'b11. In a cycle after no start, `ea_o`, `direct_o`, `wb_data_o`, `xlat_req_o` and `asid_o` keep their values.
- R9: `xlat_req_o` is set after a start exactly when `xlat_en_i`=1 and the mode is not 2'b00.
- R10: `asid_o` equals `asid_i` when `xlat_req_o` is set and `single_space_i`=0. Otherwise it is 0.
- R11: Every output reflects the inputs sampled at the clock edge where `start_i` is high, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sample the inputs and compute |
| mode_i | input | 2 | Addressing mode |
| size_i | input | 2 | Operand size |
| reg_i | input | 32 | Register contents |
| xlat_en_i | input | 1 | Address translation enabled |
| single_space_i | input | 1 | One shared virtual space |
| asid_i | input | 8 | Current address-space identifier |
| ea_o | output | 32 | Effective address (operand value in direct mode) |
| direct_o | output | 1 | Register-direct operand, no memory access |
| wb_data_o | output | 32 | New register value |
| wb_en_o | output | 1 | Register write-back enable |
| xlat_req_o | output | 1 | Address is virtual and needs translation |
| asid_o | output | 8 | Address-space identifier for the access |

## Verification
The assertions assume that `start_i`, `mode_i`, `size_i` and `reg_i` are known and stable around the sampling edge. They also assume that reset is held for at least one edge before the first start. The bench drives every input on the falling clock edge and raises `start_i` for one cycle per operation, with idle cycles in between. This keeps the hold and single-pulse properties meaningful. Random register values, modes, sizes and control bits come from a fixed seed. Directed cases hit the wrap boundaries at zero and at all-ones.

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen #(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] reg_i,
  input  logic          xlat_en_i,
  input  logic          single_space_i,
  input  logic [IW-1:0] asid_i,
  output logic [AW-1:0] ea_o,
  output logic          direct_o,
  output logic [AW-1:0] wb_data_o,
  output logic          wb_en_o,
  output logic          xlat_req_o,
  output logic [IW-1:0] asid_o
);
  localparam logic [1:0] M_DIR = 2'b00, M_IND = 2'b01, M_INC = 2'b10, M_DEC = 2'b11;

  logic [AW-1:0] step, up, down, ea_n, wb_n;
  logic          is_mem, modify;

  assign step   = AW'(1) << size_i;
  assign up     = reg_i + step;
  assign down   = reg_i - step;
  assign is_mem = (mode_i != M_DIR);
  assign modify = (mode_i == M_INC) || (mode_i == M_DEC);
  assign ea_n   = (mode_i == M_DEC) ? down : reg_i;
  assign wb_n   = (mode_i == M_INC) ? up : ((mode_i == M_DEC) ? down : reg_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_o       <= '0;
      direct_o   <= 1'b0;
      wb_data_o  <= '0;
      wb_en_o    <= 1'b0;
      xlat_req_o <= 1'b0;
      asid_o     <= '0;
    end else begin
      wb_en_o <= start_i && modify;
      if (start_i) begin
        ea_o       <= ea_n;
        direct_o   <= !is_mem;
        wb_data_o  <= wb_n;
        xlat_req_o <= xlat_en_i && is_mem;
        asid_o     <= (xlat_en_i && is_mem && !single_space_i) ? asid_i : '0;
      end
    end
  end

  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && mode_i == M_DIR |=> direct_o && !wb_en_o && !xlat_req_o && asid_o == '0 && ea_o == $past(reg_i));

  assert_indirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && mode_i == M_IND |=> !direct_o && !wb_en_o && ea_o == $past(reg_i) && wb_data_o == ea_o);

  assert_postinc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && mode_i == M_INC |=> wb_en_o && ea_o == $past(reg_i)
      && (wb_data_o - ea_o) == (AW'(1) << $past(size_i)));

  assert_predec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && mode_i == M_DEC |=> wb_en_o && ea_o == wb_data_o
      && ($past(reg_i) - ea_o) == (AW'(1) << $past(size_i)));

  assert_wb_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !wb_en_o && $stable(ea_o) && $stable(wb_data_o) && $stable(asid_o));

  assert_asid_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    asid_o != '0 |-> xlat_req_o && !direct_o);

  assert_xlat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> xlat_req_o == ($past(xlat_en_i) && !direct_o));
endmodule

// File: tb/opnd_ea_gen_tb.sv
module opnd_ea_gen_tb_top;
  logic        clk = 0, rst_n = 0, start = 0, xe = 0, ss = 0;
  logic [1:0]  mode = 0, size = 0;
  logic [31:0] rv = 0;
  logic [7:0]  asid = 0;
  logic [31:0] ea, wbd;
  logic        dir, wbe, xr;
  logic [7:0]  asid_q;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  opnd_ea_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .size_i(size),
    .reg_i(rv), .xlat_en_i(xe), .single_space_i(ss), .asid_i(asid),
    .ea_o(ea), .direct_o(dir), .wb_data_o(wbd), .wb_en_o(wbe),
    .xlat_req_o(xr), .asid_o(asid_q));

  function automatic logic [31:0] stepf(logic [1:0] s);
    case (s)
      2'b00: return 32'd1;
      2'b01: return 32'd2;
      2'b10: return 32'd4;
      default: return 32'd8;
    endcase
  endfunction

  function automatic logic [31:0] exp_ea(logic [1:0] m, logic [1:0] s, logic [31:0] r);
    return (m == 2'b11) ? r - stepf(s) : r;
  endfunction

  function automatic logic [31:0] exp_wb(logic [1:0] m, logic [1:0] s, logic [31:0] r);
    if (m == 2'b10) return r + stepf(s);
    if (m == 2'b11) return r - stepf(s);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [1:0] m, logic [1:0] s, logic [31:0] r, logic x, logic sg, logic [7:0] a);
    logic [31:0] e_ea, e_wb;
    logic        mem;
    mode = m; size = s; rv = r; xe = x; ss = sg; asid = a; start = 1;
    @(negedge clk);
    start = 0;
    mem  = (m != 2'b00);
    e_ea = exp_ea(m, s, r);
    e_wb = exp_wb(m, s, r);
    chk("R11/R4/R5 ea", ea, e_ea);
    chk("R6/R7 wb_data", wbd, e_wb);
    chk("R2 direct", 32'(dir), 32'(!mem));
    chk("R8 wb_en", 32'(wbe), 32'(m[1]));
    chk("R9 xlat_req", 32'(xr), 32'(x && mem));
    chk("R10 asid", 32'(asid_q), 32'((x && mem && !sg) ? a : 8'h0));
    rv = ~r; mode = ~m; asid = ~a; xe = ~x;
    @(negedge clk);
    chk("R8 wb_en single pulse", 32'(wbe), 32'd0);
    chk("R8 ea hold", ea, e_ea);
    chk("R8 wb_data hold", wbd, e_wb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk("R1 reset ea", ea, 0);
    chk("R1 reset wb_en", 32'(wbe), 0);
    chk("R1 reset asid", 32'(asid_q), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {wbd[30:0], dir}, 0);
    chk("R1 idle xlat", 32'(xr), 0);
    for (int s = 0; s < 4; s++) begin
      run(2'b10, 2'(s), 32'h1000, 1, 0, 8'h5A);
      run(2'b11, 2'(s), 32'h1000, 1, 0, 8'h5A);
    end
    run(2'b10, 2'b00, 32'hFFFF_FFFF, 0, 0, 8'h11);
    run(2'b10, 2'b11, 32'hFFFF_FFFC, 1, 1, 8'h22);
    run(2'b11, 2'b11, 32'h0, 1, 0, 8'h33);
    run(2'b11, 2'b00, 32'h0, 0, 1, 8'h44);
    run(2'b00, 2'b11, 32'hDEAD_BEEF, 1, 0, 8'h77);
    run(2'b01, 2'b10, 32'hCAFE_0000, 1, 1, 8'h99);
    run(2'b01, 2'b01, 32'h8000_0000, 1, 0, 8'hFF);
    for (int i = 0; i < 400; i++)
      run(2'($urandom), 2'($urandom), $urandom, 1'($urandom), 1'($urandom), 8'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule